// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

This block is a single DMA channel. Software sets a mode and a pointer and pulses start. The engine then reads a four-word descriptor from memory. The words are, in order: the next-descriptor pointer, the source address, the target address and the command word. The engine moves the requested byte count from source to target in bursts. Each burst is first read into a local buffer of up to 32 bytes and then written out. When the count reaches zero it either stops or loads the next descriptor and carries on without software help. A descriptor pointer can be redirected 32 bytes forward when a compare flag is set, which gives a two-way branch in a chain.

The channel can also be paced by a peripheral. With source or target flow control set in the command word, no burst begins unless the peripheral request is high. If the request has dropped once a burst ends, an end-of-receive flag is raised. Depending on two control inputs, the channel then stops or jumps to the next descriptor. A no-fetch mode starts straight from source, target and command values already held in the configuration inputs.

Memory is reached through a simple master port. It carries one beat at a time, with address, write data and byte enables held until ready is seen.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is idle: `st_running`=0, `st_stopped`=1, `m_req`=0, and every flag plus `st_len` are 0.
- R2: A start in fetch mode reads four 32-bit words at the pointer with its low 4 bits cleared. The words are, in order: next pointer, source, target, command. The copy uses them.
- R3: When pointer bit 1 is set and `ctl_cmp_flag` is high as a fetch begins, the descriptor is read from the cleared pointer plus 32.
- R4: Command bits 12:0 give the byte length and bits 17:16 the burst code (4 << code bytes). Data moves in bursts of min(remaining, burst). The remaining length is written back and shown on `st_len`.
- R5: Command bits 15:14 give the beat width (code 1 → 1 byte, 2 → 2 bytes, 3 or 0 → 4 bytes). Bit 31 makes the source address advance by the width per beat, and bit 30 does the same for the target. An address whose bit is clear stays fixed.
- R6: Descriptor reads use byte enables 4'b1111. Data beats enable width-many lanes starting at lane address[1:0], and data sits on those lanes.
- R7: Once `m_req` rises, the address, the direction and the byte enables hold until `m_ready` is seen.
- R8: Loading a descriptor from memory whose command bit 22 is set raises `st_start_irq`. With that bit clear, the flag stays 0.
- R9: At zero length, `st_end_irq` is set if command bit 21 is set. The channel stops (`st_running`=0, `st_stopped`=1) if no-fetch mode is active, next-pointer bit 0 is set, or `ctl_eor_stop` is high.
- R10: At zero length with none of the stop conditions, the next descriptor is fetched from the next pointer and run automatically.
- R11: In no-fetch mode a start copies using `cfg_src`, `cfg_dst` and `cfg_cmd` with no descriptor read, and `st_start_irq` stays 0.
- R12: With command bit 29 (source) or 28 (target) set, the low two bits of that address are cleared on load. No bus beat starts while `periph_req` is low.
- R13: If `periph_req` is low when a flow-controlled burst ends, `st_eor` is set. The channel then stops with the remaining length if `ctl_eor_stop` is high, or else fetches the next descriptor if `ctl_eor_jump` is high and the mode is not no-fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_start | input | 1 | Start pulse, taken only while idle |
| ctl_nofetch | input | 1 | Start without a descriptor fetch |
| ctl_eor_stop | input | 1 | Stop on end-of-receive or at zero length |
| ctl_eor_jump | input | 1 | Fetch the next descriptor on end-of-receive |
| ctl_cmp_flag | input | 1 | Compare status, used for branching |
| cfg_ptr | input | 32 | Initial descriptor pointer |
| cfg_src | input | 32 | Source address for no-fetch mode |
| cfg_dst | input | 32 | Target address for no-fetch mode |
| cfg_cmd | input | 32 | Command word for no-fetch mode |
| periph_req | input | 1 | Mapped peripheral request |
| m_req | output | 1 | Beat request |
| m_we | output | 1 | Beat is a write |
| m_addr | output | 32 | Beat byte address |
| m_be | output | 4 | Byte enables |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, valid with ready |
| m_ready | input | 1 | Beat accepted |
| st_running | output | 1 | Channel active |
| st_stopped | output | 1 | Channel stopped |
| st_start_irq | output | 1 | Start-interrupt flag |
| st_end_irq | output | 1 | End-interrupt flag |
| st_eor | output | 1 | End-of-receive flag |
| st_len | output | 13 | Remaining length |

## Verification
A bad descriptor latch or a wrong branch offset shows at once on `m_addr` in the beats that follow the fetch. Its lasting trace is target words that are missing, misplaced or copied from the wrong source, visible after the channel stops. Errors in the burst count or the length write-back appear in `st_len` after the first burst under flow control. Lane or width faults corrupt neighbouring bytes of a partly written word, so byte-level copies are checked against pre-filled target words. A wrong stop or chain decision shows within a few cycles of the last write as the wrong `st_running` level or as extra bus beats.

// File: rtl/dma_chan_pkg.sv
// Shared types and command-word field positions for the DMA channel engine.
// Assumes a 32-bit data path; field positions are fixed by the descriptor format.
package dma_chan_pkg;

    localparam int CMD_INC_SRC   = 31;
    localparam int CMD_INC_DST   = 30;
    localparam int CMD_FLOW_SRC  = 29;
    localparam int CMD_FLOW_DST  = 28;
    localparam int CMD_START_IE  = 22;
    localparam int CMD_END_IE    = 21;
    localparam int CMD_BURST_LO  = 16;
    localparam int CMD_WIDTH_LO  = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ARM,
        ST_READ,
        ST_WRITE,
        ST_POST
    } eng_state_t;

    // Beat width in bytes from the 2-bit width code (0 is reserved and treated as a word).
    function automatic logic [2:0] beat_bytes(input logic [1:0] code);
        case (code)
            2'd1:    beat_bytes = 3'd1;
            2'd2:    beat_bytes = 3'd2;
            default: beat_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_lane_map.sv
// Byte-enable generator: turns a beat width and the low address bits into lane enables.
// Assumes beats are naturally aligned to their width, so no lane wraps.
module dma_lane_map #(
    parameter int LANES = 4
) (
    input  logic [2:0]               width,
    input  logic [$clog2(LANES)-1:0] lane,
    output logic [LANES-1:0]         be
);
    logic [2*LANES-1:0] ones;

    // Build a width-long run of ones and shift it to the starting lane.
    always_comb begin
        ones = ((2*LANES)'(1) << width) - (2*LANES)'(1);
        be   = LANES'(ones << lane);
    end

endmodule

// File: rtl/dma_burst_buf.sv
// Burst staging buffer: captures read beats byte by byte at a burst offset and
// presents the same bytes on the proper lanes for the write beats.
// Data storage carries no reset; contents are always written before being read.
module dma_burst_buf #(
    parameter int BUF_BYTES = 32,
    parameter int OFF_W     = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             cap_en,
    input  logic [OFF_W:0]   off,
    input  logic [1:0]       lane,
    input  logic [2:0]       width,
    input  logic [31:0]      din,
    output logic [31:0]      dout
);
    logic [7:0] bytes_q [BUF_BYTES];

    // Store each enabled lane of a read beat at offset + byte index.
    always_ff @(posedge clk) begin
        if (cap_en) begin
            for (int i = 0; i < 4; i++) begin
                logic [OFF_W:0] idx;
                logic [1:0]     ln;
                idx = off + (OFF_W+1)'(i);
                ln  = lane + 2'(i);
                if (i < int'(width) && idx < (OFF_W+1)'(BUF_BYTES))
                    bytes_q[idx[OFF_W-1:0]] <= din[8*ln +: 8];
            end
        end
    end

    // Place buffered bytes for the current write beat onto their lanes.
    always_comb begin
        dout = '0;
        for (int i = 0; i < 4; i++) begin
            logic [OFF_W:0] idx;
            logic [1:0]     ln;
            idx = off + (OFF_W+1)'(i);
            ln  = lane + 2'(i);
            if (i < int'(width) && idx < (OFF_W+1)'(BUF_BYTES))
                dout[8*ln +: 8] = bytes_q[idx[OFF_W-1:0]];
        end
    end

endmodule

// File: rtl/dma_chan_engine.sv
// One descriptor-chained DMA channel. Fetches a four-word descriptor (next
// pointer, source, target, command), copies data in buffered bursts, then stops,
// chains, or reacts to end-of-receive under peripheral flow control.
// Assumes a 32-bit single-beat master port and aligned narrow beats.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 13,
    parameter int BUF_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_start,
    input  logic              ctl_nofetch,
    input  logic              ctl_eor_stop,
    input  logic              ctl_eor_jump,
    input  logic              ctl_cmp_flag,
    input  logic [ADDR_W-1:0] cfg_ptr,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [31:0]       cfg_cmd,
    input  logic              periph_req,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [3:0]        m_be,
    output logic [31:0]       m_wdata,
    input  logic [31:0]       m_rdata,
    input  logic              m_ready,
    output logic              st_running,
    output logic              st_stopped,
    output logic              st_start_irq,
    output logic              st_end_irq,
    output logic              st_eor,
    output logic [LEN_W-1:0]  st_len
);
    localparam int OFF_W = $clog2(BUF_BYTES);
    localparam logic [ADDR_W-1:0] ALT_STEP = ADDR_W'(32);

    eng_state_t        state_q;
    logic [ADDR_W-1:0] ptr_q, src_q, dst_q, fetch_base_q;
    logic [31:0]       cmd_q;
    logic [1:0]        widx_q;
    logic [OFF_W:0]    off_q, bsz_q;
    logic              nofetch_q;

    logic [2:0]        beat_w;
    logic [OFF_W:0]    burst_sz;
    logic [LEN_W-1:0]  len;
    logic              flow, beat_done, last_beat, eor_hit, len_zero, halt, chain;
    logic [3:0]        data_be;
    logic [31:0]       buf_dout;

    // Descriptor address: low nibble ignored, +32 when branch bit and compare flag are set.
    function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] p, input logic cmp);
        desc_addr = (p & ~ADDR_W'(15)) + ((p[1] && cmp) ? ALT_STEP : '0);
    endfunction

    // Decode the active command word and the per-beat conditions.
    always_comb begin
        beat_w    = beat_bytes(cmd_q[CMD_WIDTH_LO +: 2]);
        burst_sz  = (OFF_W+1)'(4) << cmd_q[CMD_BURST_LO +: 2];
        len       = cmd_q[LEN_W-1:0];
        flow      = cmd_q[CMD_FLOW_SRC] | cmd_q[CMD_FLOW_DST];
        beat_done = m_req & m_ready;
        last_beat = (off_q + (OFF_W+1)'(beat_w)) >= bsz_q;
        len_zero  = (len == '0);
        eor_hit   = flow && !periph_req && (bsz_q != '0);
        halt      = (eor_hit && ctl_eor_stop) ||
                    (len_zero && (nofetch_q || ptr_q[0] || ctl_eor_stop));
        chain     = (eor_hit && ctl_eor_jump && !nofetch_q) || len_zero;
    end

    dma_lane_map #(.LANES(4)) u_lanes (
        .width (beat_w),
        .lane  (m_addr[1:0]),
        .be    (data_be)
    );

    dma_burst_buf #(.BUF_BYTES(BUF_BYTES), .OFF_W(OFF_W)) u_buf (
        .clk    (clk),
        .cap_en (state_q == ST_READ && beat_done),
        .off    (off_q),
        .lane   (m_addr[1:0]),
        .width  (beat_w),
        .din    (m_rdata),
        .dout   (buf_dout)
    );

    // Drive the master port from the current state.
    always_comb begin
        m_req   = (state_q == ST_FETCH) || (state_q == ST_READ) || (state_q == ST_WRITE);
        m_we    = (state_q == ST_WRITE);
        m_wdata = buf_dout;
        case (state_q)
            ST_FETCH: m_addr = fetch_base_q + {{(ADDR_W-4){1'b0}}, widx_q, 2'b00};
            ST_WRITE: m_addr = dst_q;
            default:  m_addr = src_q;
        endcase
        m_be = (state_q == ST_FETCH) ? 4'hF : data_be;
    end

    // Channel sequencer: start, descriptor fetch, burst read/write, post-burst decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            ptr_q        <= '0;
            src_q        <= '0;
            dst_q        <= '0;
            fetch_base_q <= '0;
            cmd_q        <= '0;
            widx_q       <= '0;
            off_q        <= '0;
            bsz_q        <= '0;
            nofetch_q    <= 1'b0;
            st_running   <= 1'b0;
            st_stopped   <= 1'b1;
            st_start_irq <= 1'b0;
            st_end_irq   <= 1'b0;
            st_eor       <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (ctl_start) begin
                    st_running   <= 1'b1;
                    st_stopped   <= 1'b0;
                    st_start_irq <= 1'b0;
                    st_end_irq   <= 1'b0;
                    st_eor       <= 1'b0;
                    nofetch_q    <= ctl_nofetch;
                    ptr_q        <= cfg_ptr;
                    if (ctl_nofetch) begin
                        cmd_q   <= cfg_cmd;
                        src_q   <= cfg_cmd[CMD_FLOW_SRC] ? (cfg_src & ~ADDR_W'(3)) : cfg_src;
                        dst_q   <= cfg_cmd[CMD_FLOW_DST] ? (cfg_dst & ~ADDR_W'(3)) : cfg_dst;
                        state_q <= ST_ARM;
                    end else begin
                        fetch_base_q <= desc_addr(cfg_ptr, ctl_cmp_flag);
                        widx_q       <= '0;
                        state_q      <= ST_FETCH;
                    end
                end
                ST_FETCH: if (beat_done) begin
                    widx_q <= widx_q + 2'd1;
                    case (widx_q)
                        2'd0: ptr_q <= m_rdata;
                        2'd1: src_q <= m_rdata;
                        2'd2: dst_q <= m_rdata;
                        default: begin
                            cmd_q <= m_rdata;
                            if (m_rdata[CMD_FLOW_SRC]) src_q[1:0] <= 2'b00;
                            if (m_rdata[CMD_FLOW_DST]) dst_q[1:0] <= 2'b00;
                            if (m_rdata[CMD_START_IE]) st_start_irq <= 1'b1;
                            state_q <= ST_ARM;
                        end
                    endcase
                end
                ST_ARM: begin
                    off_q <= '0;
                    if (len_zero) begin
                        bsz_q   <= '0;
                        state_q <= ST_POST;
                    end else if (!flow || periph_req) begin
                        bsz_q   <= (len < LEN_W'(burst_sz)) ? (OFF_W+1)'(len) : burst_sz;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: if (beat_done) begin
                    if (cmd_q[CMD_INC_SRC]) src_q <= src_q + ADDR_W'(beat_w);
                    off_q <= last_beat ? '0 : off_q + (OFF_W+1)'(beat_w);
                    if (last_beat) state_q <= ST_WRITE;
                end
                ST_WRITE: if (beat_done) begin
                    if (cmd_q[CMD_INC_DST]) dst_q <= dst_q + ADDR_W'(beat_w);
                    off_q <= off_q + (OFF_W+1)'(beat_w);
                    if (last_beat) begin
                        cmd_q   <= {cmd_q[31:LEN_W], len - LEN_W'(bsz_q)};
                        state_q <= ST_POST;
                    end
                end
                ST_POST: begin
                    if (eor_hit) st_eor <= 1'b1;
                    if (len_zero && cmd_q[CMD_END_IE]) st_end_irq <= 1'b1;
                    if (halt) begin
                        st_running <= 1'b0;
                        st_stopped <= 1'b1;
                        state_q    <= ST_IDLE;
                    end else if (chain) begin
                        fetch_base_q <= desc_addr(ptr_q, ctl_cmp_flag);
                        widx_q       <= '0;
                        state_q      <= ST_FETCH;
                    end else begin
                        state_q <= ST_ARM;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign st_len = len;

    // R7
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_be)));

    // R6
    be_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> ($countones(m_be) == 1 || $countones(m_be) == 2 || $countones(m_be) == 4));

    // R9
    stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_running) |-> st_stopped);

    // R12
    flow_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && flow && !periph_req) |=> !m_req);

    // R4
    len_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |=> (st_len <= $past(st_len)));

endmodule

// File: tb/sim_dma_chan_engine.sv
// Directed bench: a word memory with one wait state per beat, one task per scenario.
module sim_dma_chan_engine;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] INC_S = 32'h8000_0000;
    localparam logic [31:0] INC_D = 32'h4000_0000;
    localparam logic [31:0] FLOW_S = 32'h2000_0000;
    localparam logic [31:0] START_IE = 32'h0040_0000;
    localparam logic [31:0] END_IE = 32'h0020_0000;
    localparam logic [31:0] W4 = 32'h0000_C000;
    localparam logic [31:0] W1 = 32'h0000_4000;
    localparam logic [31:0] B8 = 32'h0001_0000;
    localparam logic [31:0] B16 = 32'h0002_0000;

    logic clk = 0, rst_n = 0;
    logic ctl_start = 0, ctl_nofetch = 0, ctl_eor_stop = 0, ctl_eor_jump = 0, ctl_cmp_flag = 0;
    logic [31:0] cfg_ptr = 0, cfg_src = 0, cfg_dst = 0, cfg_cmd = 0;
    logic periph_req = 0;
    logic m_req, m_we, m_ready;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [3:0] m_be;
    logic st_running, st_stopped, st_start_irq, st_end_irq, st_eor;
    logic [12:0] st_len;

    logic [31:0] mem [256];
    logic rdy_q;
    int checks = 0, fails = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_engine u0 (
        .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_nofetch(ctl_nofetch),
        .ctl_eor_stop(ctl_eor_stop), .ctl_eor_jump(ctl_eor_jump), .ctl_cmp_flag(ctl_cmp_flag),
        .cfg_ptr(cfg_ptr), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cmd(cfg_cmd),
        .periph_req(periph_req), .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_be(m_be),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .st_running(st_running),
        .st_stopped(st_stopped), .st_start_irq(st_start_irq), .st_end_irq(st_end_irq),
        .st_eor(st_eor), .st_len(st_len)
    );

    assign m_ready = rdy_q;
    assign m_rdata = mem[m_addr[9:2]];

    // Memory responder: one wait cycle per beat, byte-enabled writes.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) rdy_q <= 1'b0;
        else rdy_q <= m_req && !rdy_q;
        if (m_req && m_we && m_ready)
            for (int b = 0; b < 4; b++)
                if (m_be[b]) mem[m_addr[9:2]][8*b +: 8] <= m_wdata[8*b +: 8];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++)
            mem[i] = (i < 64) ? 32'h0 : (i < 128) ? {16'hC0DE, 8'(i), 8'(i ^ 8'h5A)} : 32'hDEAD_BEEF;
    endtask

    task automatic put_desc(input int a, input logic [31:0] nx, s, d, c);
        mem[a/4] = nx; mem[a/4+1] = s; mem[a/4+2] = d; mem[a/4+3] = c;
    endtask

    task automatic go_and_wait(input string req);
        @(negedge clk) ctl_start = 1;
        @(negedge clk) ctl_start = 0;
        for (int n = 0; n < 3000 && st_running; n++) @(negedge clk);
        chk({req, " finished"}, 32'(st_running), 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 m_req", 32'(m_req), 0);
        chk("R1 running", 32'(st_running), 0);
        chk("R1 stopped", 32'(st_stopped), 1);
        chk("R1 flags", {st_start_irq, st_end_irq, st_eor}, 0);
        chk("R1 len", 32'(st_len), 0);
    endtask

    task automatic t_single();
        init_mem();
        put_desc(32'h40, 32'h1, 32'h100, 32'h200, INC_S | INC_D | START_IE | END_IE | W4 | B8 | 32'd20);
        cfg_ptr = 32'h4C;
        go_and_wait("R2");
        for (int k = 0; k < 5; k++) chk("R2 R4 copy", mem[32'h200/4 + k], mem[32'h100/4 + k]);
        chk("R4 copy bound", mem[32'h214/4], 32'hDEAD_BEEF);
        chk("R4 len", 32'(st_len), 0);
        chk("R8 start", 32'(st_start_irq), 1);
        chk("R9 end", 32'(st_end_irq), 1);
        chk("R9 stopped", 32'(st_stopped), 1);
    endtask

    task automatic t_chain();
        init_mem();
        put_desc(32'h60, 32'h80, 32'h140, 32'h240, INC_S | INC_D | W4 | B16 | 32'd8);
        put_desc(32'h80, 32'h1, 32'h150, 32'h260, INC_S | INC_D | END_IE | W4 | B16 | 32'd8);
        cfg_ptr = 32'h60;
        go_and_wait("R10");
        for (int k = 0; k < 2; k++) begin
            chk("R10 first", mem[32'h240/4 + k], mem[32'h140/4 + k]);
            chk("R10 second", mem[32'h260/4 + k], mem[32'h150/4 + k]);
        end
        chk("R8 no start", 32'(st_start_irq), 0);
        chk("R9 end chained", 32'(st_end_irq), 1);
    endtask

    task automatic t_branch();
        init_mem();
        put_desc(32'hA0, 32'h1, 32'h160, 32'h280, INC_S | INC_D | W4 | 32'd4);
        put_desc(32'hC0, 32'h1, 32'h160, 32'h2A0, INC_S | INC_D | W4 | 32'd4);
        cfg_ptr = 32'hA2; ctl_cmp_flag = 1;
        go_and_wait("R3");
        ctl_cmp_flag = 0;
        chk("R3 alt used", mem[32'h2A0/4], mem[32'h160/4]);
        chk("R3 primary skipped", mem[32'h280/4], 32'hDEAD_BEEF);
    endtask

    task automatic t_bytes();
        init_mem();
        mem[32'h170/4] = 32'h4433_2211;
        mem[32'h2C0/4] = 32'hAAAA_AAAA;
        put_desc(32'hE0, 32'h1, 32'h170, 32'h2C0, INC_D | W1 | 32'd3);
        cfg_ptr = 32'hE0;
        @(negedge clk) ctl_start = 1;
        @(negedge clk) ctl_start = 0;
        for (int n = 0; n < 500 && !(m_req && m_we && m_addr == 32'h2C1); n++) @(negedge clk);
        chk("R6 byte lane", 32'(m_be), 32'h2);
        for (int n = 0; n < 500 && st_running; n++) @(negedge clk);
        chk("R5 fixed src inc dst", mem[32'h2C0/4], 32'hAA11_1111);
    endtask

    task automatic t_nofetch();
        init_mem();
        ctl_nofetch = 1;
        cfg_ptr = 32'h0; cfg_src = 32'h180; cfg_dst = 32'h2D0;
        cfg_cmd = INC_S | INC_D | START_IE | W4 | 32'd8;
        go_and_wait("R11");
        ctl_nofetch = 0;
        chk("R11 copy0", mem[32'h2D0/4], mem[32'h180/4]);
        chk("R11 copy1", mem[32'h2D4/4], mem[32'h184/4]);
        chk("R11 no start", 32'(st_start_irq), 0);
        chk("R9 stopped nofetch", 32'(st_stopped), 1);
    endtask

    task automatic t_eor_stop();
        int busy;
        init_mem();
        put_desc(32'h10, 32'h1, 32'h1A3, 32'h300, FLOW_S | INC_S | INC_D | W4 | B16 | 32'd32);
        cfg_ptr = 32'h10; ctl_eor_stop = 1; periph_req = 0;
        @(negedge clk) ctl_start = 1;
        @(negedge clk) ctl_start = 0;
        repeat (30) @(negedge clk);
        busy = 0;
        for (int n = 0; n < 20; n++) begin @(negedge clk); busy += int'(m_req); end
        chk("R12 waits for request", 32'(busy), 0);
        periph_req = 1;
        for (int n = 0; n < 500 && !(m_req && !m_we && m_addr[8]); n++) @(negedge clk);
        periph_req = 0;
        for (int n = 0; n < 500 && st_running; n++) @(negedge clk);
        ctl_eor_stop = 0;
        for (int k = 0; k < 4; k++) chk("R12 aligned copy", mem[32'h300/4 + k], mem[32'h1A0/4 + k]);
        chk("R13 stop keeps rest", mem[32'h310/4], 32'hDEAD_BEEF);
        chk("R13 eor", 32'(st_eor), 1);
        chk("R13 len", 32'(st_len), 16);
    endtask

    task automatic t_eor_jump();
        init_mem();
        put_desc(32'h20, 32'h30, 32'h1C0, 32'h340, FLOW_S | INC_S | INC_D | W4 | B16 | 32'd32);
        put_desc(32'h30, 32'h1, 32'h1D0, 32'h380, INC_S | INC_D | W4 | B16 | 32'd4);
        cfg_ptr = 32'h20; ctl_eor_jump = 1; periph_req = 1;
        @(negedge clk) ctl_start = 1;
        @(negedge clk) ctl_start = 0;
        for (int n = 0; n < 500 && !(m_req && !m_we && m_addr[8]); n++) @(negedge clk);
        periph_req = 0;
        for (int n = 0; n < 500 && st_running; n++) @(negedge clk);
        ctl_eor_jump = 0;
        chk("R13 partial", mem[32'h34C/4], mem[32'h1CC/4]);
        chk("R13 rest skipped", mem[32'h350/4], 32'hDEAD_BEEF);
        chk("R13 jumped copy", mem[32'h380/4], mem[32'h1D0/4]);
        chk("R13 eor jump", 32'(st_eor), 1);
    endtask

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_branch();
        t_bytes();
        t_nofetch();
        t_eor_stop();
        t_eor_jump();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule